// File: doc/BRIEF.md
# Oversampling Accumulator Scan Sequencer

This controller drives a successive-approximation converter core through a scan of several input channels. A start pulse begins the scan. For each channel in ascending order it runs 2^k conversions and sums the offset-corrected samples in a 20-bit accumulator. The sum is then rounded and right-shifted by a programmable amount, and the result is written to that channel's result field. With a sample count of 256 and a shift of 8, the full 12-bit scale comes back out.

Each conversion starts with a tracking window whose length is programmable in half-cycles of the converter clock; the controller runs at twice the converter clock, so one half-cycle is one controller cycle. A one-cycle convert command follows, and the core then answers with a valid pulse after its fixed conversion time. The core model in the bench uses 25 controller cycles, which is 12.5 converter clocks. The first start after reset that has calibration enabled inserts one zero-offset conversion ahead of channel 0. The code it returns is kept as the offset and is subtracted from every later sample.

Top module: `ovs_scan_ctrl`

## Requirements
- R1: After reset, adc_track, adc_convert, adc_cal, ch_done, scan_done and every result field are 0.
- R2: Each conversion holds adc_track high for exactly cfg_track+1 consecutive cycles. adc_convert follows for exactly one cycle in the next cycle. The controller then waits for adc_valid before starting anything else.
- R3: Each channel gets 2^k conversions, where k is cfg_log2_cnt with values above 8 treated as 8. The channels run from 0 to NCH-1 in order, and adc_chan shows the channel being converted.
- R4: A channel's result is (sum + 2^(s-1)) >> s, where s is cfg_shift with values above 8 treated as 8. No rounding term is added when s is 0. Channel c's result sits in result_flat[c*20 +: 20].
- R5: When a start is accepted with cfg_cal_en=1 and no calibration has run since reset, exactly one conversion with adc_cal=1 runs before channel 0, and its adc_data is stored as the offset. Later starts never calibrate again.
- R6: Each sample added to the sum is adc_data minus the stored offset, or 0 if adc_data is not above the offset. The offset is 0 until a calibration has run.
- R7: ch_done[c] rises when channel c's result is written. scan_done rises once the last channel is written and holds until the next accepted start, which clears both.
- R8: A start while a scan is running is ignored. k, s and the track length are captured when a start is accepted, so changing the configuration inputs during a scan has no effect on that scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (twice the converter clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start-of-scan pulse |
| cfg_log2_cnt | input | 4 | Log2 of the conversions per channel (clamped to 8) |
| cfg_shift | input | 4 | Right shift applied to the sum (clamped to 8) |
| cfg_track | input | 8 | Tracking window minus one, in half converter cycles |
| cfg_cal_en | input | 1 | Run the one-time offset calibration |
| adc_track | output | 1 | Core tracks the input |
| adc_convert | output | 1 | One-cycle convert command |
| adc_cal | output | 1 | Current conversion is the zero calibration |
| adc_chan | output | 2 | Channel being converted |
| adc_valid | input | 1 | Core result valid pulse |
| adc_data | input | 12 | Core conversion result |
| result_flat | output | 60 | Per-channel averaged results, 20 bits each |
| ch_done | output | 3 | Per-channel result-written flags |
| scan_done | output | 1 | All channels written |

## Verification
Most internal faults show up as a wrong result, and only at the end of the affected channel. A miscounted sample or a wrong rounding term gives a result that is off by a predictable amount. A stale accumulator shifts every channel after the first. A bad tracking counter is visible on the first conversion of the scan, as a track run of the wrong length in front of the convert pulse. A broken calibration latch shows as an extra adc_cal conversion on the second calibrated start, or as channel results that do not reflect the offset. The sweep covers every sample count from 1 to 256 and several shifts.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_TRACK = 3'd1,
        S_CONV  = 3'd2,
        S_WAIT  = 3'd3,
        S_STORE = 3'd4
    } ovs_state_t;

endpackage

// File: rtl/ovs_sat_sub.sv
module ovs_sat_sub #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [DATA_W-1:0] offset,
    output logic [DATA_W-1:0] corrected
);

    // Clip at zero so that a sample below the stored offset cannot wrap around.
    always_comb begin
        if (raw > offset) begin
            corrected = raw - offset;
        end else begin
            corrected = '0;
        end
    end

endmodule

// File: rtl/ovs_round_shift.sv
module ovs_round_shift #(
    parameter int ACC_W = 20
) (
    input  logic [ACC_W-1:0] sum,
    input  logic [3:0]       shift,
    output logic [ACC_W-1:0] scaled
);

    logic [ACC_W:0] half;
    logic [ACC_W:0] total;

    // Add half of the LSB that survives the shift, then shift.
    always_comb begin
        if (shift == 4'd0) begin
            half = '0;
        end else begin
            half = (ACC_W+1)'(1) << (shift - 4'd1);
        end
        total  = {1'b0, sum} + half;
        scaled = ACC_W'(total >> shift);
    end

endmodule

// File: rtl/ovs_scan_ctrl.sv
module ovs_scan_ctrl
    import ovs_pkg::*;
#(
    parameter int NCH       = 3,
    parameter int DATA_W    = 12,
    parameter int ACC_W     = 20,
    parameter int MAX_LOG2  = 8,
    parameter int MAX_SHIFT = 8,
    parameter int TRK_W     = 8,
    localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CNT_W    = MAX_LOG2 + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [3:0]           cfg_log2_cnt,
    input  logic [3:0]           cfg_shift,
    input  logic [TRK_W-1:0]     cfg_track,
    input  logic                 cfg_cal_en,
    output logic                 adc_track,
    output logic                 adc_convert,
    output logic                 adc_cal,
    output logic [CH_W-1:0]      adc_chan,
    input  logic                 adc_valid,
    input  logic [DATA_W-1:0]    adc_data,
    output logic [NCH*ACC_W-1:0] result_flat,
    output logic [NCH-1:0]       ch_done,
    output logic                 scan_done
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

    typedef struct packed {
        ovs_state_t                 st;
        logic                       cal_mode;
        logic                       calibrated;
        logic [DATA_W-1:0]          offset;
        logic [CH_W-1:0]            ch;
        logic [CNT_W-1:0]           cnt;
        logic [TRK_W-1:0]           tmr;
        logic [ACC_W-1:0]           acc;
        logic [3:0]                 k;
        logic [3:0]                 sh;
        logic [TRK_W-1:0]           trk;
        logic [NCH-1:0][ACC_W-1:0]  res;
        logic [NCH-1:0]             chd;
        logic                       sdone;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [DATA_W-1:0] sample_corr;
    logic [ACC_W-1:0]  rounded;
    logic [CNT_W-1:0]  cnt_last;
    logic [3:0]        k_in;
    logic [3:0]        sh_in;

    ovs_sat_sub #(
        .DATA_W(DATA_W)
    ) i_sat_sub (
        .raw      (adc_data),
        .offset   (ctl_q.offset),
        .corrected(sample_corr)
    );

    ovs_round_shift #(
        .ACC_W(ACC_W)
    ) i_round_shift (
        .sum   (ctl_q.acc),
        .shift (ctl_q.sh),
        .scaled(rounded)
    );

    always_comb begin
        k_in     = (cfg_log2_cnt > 4'(MAX_LOG2)) ? 4'(MAX_LOG2) : cfg_log2_cnt;
        sh_in    = (cfg_shift > 4'(MAX_SHIFT)) ? 4'(MAX_SHIFT) : cfg_shift;
        cnt_last = (CNT_W'(1) << ctl_q.k) - CNT_W'(1);
        ctl_d    = ctl_q;

        case (ctl_q.st)
            S_IDLE: begin
                if (start) begin
                    ctl_d.k        = k_in;
                    ctl_d.sh       = sh_in;
                    ctl_d.trk      = cfg_track;
                    ctl_d.chd      = '0;
                    ctl_d.sdone    = 1'b0;
                    ctl_d.ch       = '0;
                    ctl_d.cnt      = '0;
                    ctl_d.acc      = '0;
                    ctl_d.tmr      = '0;
                    ctl_d.cal_mode = cfg_cal_en && !ctl_q.calibrated;
                    ctl_d.st       = S_TRACK;
                end
            end
            S_TRACK: begin
                if (ctl_q.tmr == ctl_q.trk) begin
                    ctl_d.tmr = '0;
                    ctl_d.st  = S_CONV;
                end else begin
                    ctl_d.tmr = ctl_q.tmr + TRK_W'(1);
                end
            end
            S_CONV: begin
                ctl_d.st = S_WAIT;
            end
            S_WAIT: begin
                if (adc_valid) begin
                    if (ctl_q.cal_mode) begin
                        ctl_d.offset     = adc_data;
                        ctl_d.calibrated = 1'b1;
                        ctl_d.cal_mode   = 1'b0;
                        ctl_d.st         = S_TRACK;
                    end else begin
                        ctl_d.acc = ctl_q.acc + ACC_W'(sample_corr);
                        if (ctl_q.cnt == cnt_last) begin
                            ctl_d.st = S_STORE;
                        end else begin
                            ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                            ctl_d.st  = S_TRACK;
                        end
                    end
                end
            end
            S_STORE: begin
                ctl_d.res[ctl_q.ch] = rounded;
                ctl_d.chd[ctl_q.ch] = 1'b1;
                ctl_d.acc           = '0;
                ctl_d.cnt           = '0;
                if (ctl_q.ch == LAST_CH) begin
                    ctl_d.sdone = 1'b1;
                    ctl_d.st    = S_IDLE;
                end else begin
                    ctl_d.ch = ctl_q.ch + CH_W'(1);
                    ctl_d.st = S_TRACK;
                end
            end
            default: begin
                ctl_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign adc_track   = (ctl_q.st == S_TRACK);
    assign adc_convert = (ctl_q.st == S_CONV);
    assign adc_cal     = ctl_q.cal_mode;
    assign adc_chan    = ctl_q.ch;
    assign result_flat = ctl_q.res;
    assign ch_done     = ctl_q.chd;
    assign scan_done   = ctl_q.sdone;

endmodule

// File: rtl/ovs_scan_check.sv
module ovs_scan_check #(
    parameter int NCH  = 3,
    parameter int CH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            adc_track,
    input logic            adc_convert,
    input logic            adc_cal,
    input logic [CH_W-1:0] adc_chan,
    input logic [NCH-1:0]  ch_done,
    input logic            scan_done
);

    logic cal_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_seen_q <= 1'b0;
        end else if (adc_convert && adc_cal) begin
            cal_seen_q <= 1'b1;
        end
    end

    AST_TRACK_BEFORE_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convert |-> $past(adc_track)); // R2

    AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_track && adc_convert)); // R2

    AST_CONV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convert |=> !adc_convert); // R2

    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_track || adc_convert) |-> (int'(adc_chan) < NCH)); // R3

    AST_CAL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_convert && adc_cal && cal_seen_q)); // R5

    AST_CAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convert && adc_cal |-> (adc_chan == '0) && (ch_done == '0)); // R5

    AST_DONE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_done) |-> (&ch_done)); // R7

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done && !start |=> scan_done); // R7

endmodule

bind ovs_scan_ctrl ovs_scan_check #(
    .NCH (NCH),
    .CH_W(CH_W)
) i_ovs_scan_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .adc_track  (adc_track),
    .adc_convert(adc_convert),
    .adc_cal    (adc_cal),
    .adc_chan   (adc_chan),
    .ch_done    (ch_done),
    .scan_done  (scan_done)
);

// File: tb/test_ovs_scan_ctrl.sv
module test_ovs_scan_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 3;
    localparam int ACC_W      = 20;
    localparam int CONV_LAT   = 25;
    localparam int CAL_VAL    = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  cfg_log2_cnt = '0;
    logic [3:0]  cfg_shift = '0;
    logic [7:0]  cfg_track = '0;
    logic        cfg_cal_en = 1'b0;
    logic        adc_track;
    logic        adc_convert;
    logic        adc_cal;
    logic [1:0]  adc_chan;
    logic        adc_valid;
    logic [11:0] adc_data;
    logic [NCH*ACC_W-1:0] result_flat;
    logic [NCH-1:0] ch_done;
    logic        scan_done;

    int n_checks = 0;
    int n_fail   = 0;
    int scan_seed = 0;
    int exp_trk   = 0;
    bit calibrated_exp = 1'b0;

    // converter model state
    int seen_seed = -1;
    int idx [NCH];
    int lat = 0;
    logic [11:0] pend = '0;
    int trk_run = 0;
    int trk_err = 0;
    int conv_cnt = 0;
    int cal_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovs_scan_ctrl i_ovs_scan_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_log2_cnt(cfg_log2_cnt),
        .cfg_shift   (cfg_shift),
        .cfg_track   (cfg_track),
        .cfg_cal_en  (cfg_cal_en),
        .adc_track   (adc_track),
        .adc_convert (adc_convert),
        .adc_cal     (adc_cal),
        .adc_chan    (adc_chan),
        .adc_valid   (adc_valid),
        .adc_data    (adc_data),
        .result_flat (result_flat),
        .ch_done     (ch_done),
        .scan_done   (scan_done)
    );

    function automatic int gen(int seed, int ch, int i);
        if (ch == 1 && seed == 7) begin
            return i % 50;
        end
        return (seed * 97 + ch * 1301 + i * 251 + i * i * 13) % 4096;
    endfunction

    // Converter core model: fixed latency, data from gen()
    always @(posedge clk) begin
        if (!rst_n) begin
            lat       <= 0;
            adc_valid <= 1'b0;
            adc_data  <= '0;
            trk_run   <= 0;
        end else if (seen_seed != scan_seed) begin
            seen_seed <= scan_seed;
            for (int c = 0; c < NCH; c++) idx[c] <= 0;
            trk_err   <= 0;
            conv_cnt  <= 0;
            cal_cnt   <= 0;
            trk_run   <= 0;
            adc_valid <= 1'b0;
        end else begin
            adc_valid <= (lat == 1);
            if (lat == 1) adc_data <= pend;
            if (adc_convert) begin
                lat <= CONV_LAT;
                if (trk_run != exp_trk + 1) trk_err <= trk_err + 1;
                conv_cnt <= conv_cnt + 1;
                if (adc_cal) begin
                    cal_cnt <= cal_cnt + 1;
                    pend    <= 12'(CAL_VAL);
                end else begin
                    pend <= 12'(gen(scan_seed, int'(adc_chan), idx[adc_chan]));
                    idx[adc_chan] <= idx[adc_chan] + 1;
                end
            end else if (lat > 0) begin
                lat <= lat - 1;
            end
            trk_run <= adc_track ? trk_run + 1 : 0;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_scan(int seed, int k, int sh, int trk, bit cal_en, bit inject);
        int kc;
        int sc;
        int off;
        bit do_cal;
        int waited;
        kc = (k > 8) ? 8 : k;
        sc = (sh > 8) ? 8 : sh;
        do_cal = cal_en && !calibrated_exp;
        @(negedge clk);
        scan_seed    = seed;
        exp_trk      = trk;
        cfg_log2_cnt = 4'(k);
        cfg_shift    = 4'(sh);
        cfg_track    = 8'(trk);
        cfg_cal_en   = cal_en;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(scan_done == 1'b0 && ch_done == '0, "R7", "flags cleared on start",
              int'(scan_done), 0);
        if (inject) begin
            repeat (60) @(negedge clk);
            cfg_log2_cnt = 4'd0;
            cfg_shift    = 4'd0;
            cfg_track    = 8'd3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!scan_done && waited < 60000) begin
            @(negedge clk);
            waited++;
        end
        check(scan_done == 1'b1, "R7", "scan_done reached", int'(scan_done), 1);
        check(ch_done == '1, "R7", "all ch_done set", int'(ch_done), 7);
        if (do_cal) calibrated_exp = 1'b1;
        off = calibrated_exp ? CAL_VAL : 0;
        for (int c = 0; c < NCH; c++) begin
            longint sum;
            longint half;
            int expv;
            int act;
            sum = 0;
            for (int i = 0; i < (1 << kc); i++) begin
                int raw;
                raw = gen(seed, c, i);
                sum += (raw > off) ? (raw - off) : 0;
            end
            half = (sc == 0) ? 0 : (longint'(1) << (sc - 1));
            expv = int'((sum + half) >> sc);
            act  = int'(result_flat[c*ACC_W +: ACC_W]);
            check(act == expv, (off != 0) ? "R4/R6" : "R4", "channel result", act, expv);
        end
        check(conv_cnt == (NCH << kc) + (do_cal ? 1 : 0), inject ? "R8" : "R3",
              "conversion count", conv_cnt, (NCH << kc) + (do_cal ? 1 : 0));
        check(cal_cnt == (do_cal ? 1 : 0), "R5", "calibration conversions",
              cal_cnt, do_cal ? 1 : 0);
        check(trk_err == 0, "R2", "track window length errors", trk_err, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(adc_track == 0 && adc_convert == 0 && adc_cal == 0, "R1",
              "idle core controls", int'({adc_track, adc_convert, adc_cal}), 0);
        check(ch_done == '0 && scan_done == 0, "R1", "idle flags",
              int'({ch_done, scan_done}), 0);
        check(result_flat == '0, "R1", "results zero", int'(result_flat[19:0]), 0);

        run_scan(1, 0, 0, 0, 1'b0, 1'b0);   // no offset yet (R6)
        run_scan(2, 2, 2, 38, 1'b1, 1'b0);  // calibration inserted (R5)
        run_scan(7, 3, 3, 1, 1'b1, 1'b0);   // no second calibration, ch1 saturates (R5, R6)
        for (int k = 1; k <= 8; k++) begin
            run_scan(10 + k, k, k, 2, 1'b0, 1'b0);  // R3/R4 sweep
        end
        run_scan(30, 3, 0, 0, 1'b0, 1'b0);   // R4 no shift
        run_scan(31, 4, 8, 1, 1'b0, 1'b0);   // R4 shift beyond log2
        run_scan(32, 0, 12, 5, 1'b0, 1'b0);  // R4 shift clamp
        run_scan(33, 9, 8, 0, 1'b0, 1'b0);   // R3 count clamp
        run_scan(34, 2, 1, 4, 1'b0, 1'b1);   // R8 start and config ignored mid-scan

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule